// File: doc/BRIEF.md
# Guarded Byte Store Controller

This block sits on a small CPU-style register bus and gives software access to a byte-wide nonvolatile data store. The store is modelled here as an internal register array. Four registers are exposed: an address register, a data register, a control register and a write-only key register.

A read costs one bus access. Software sets the fetch bit in the control register, and the addressed byte is in the data register on the following cycle.

A write is guarded. Software must first write 55h and then AAh to the key register. The very next bus write must go to the control register and set the program bit, and the write-enable bit must already be set. The programming cycle then lasts a fixed number of clock cycles. At its end, hardware drops the program bit and raises a sticky completion flag, which can drive an interrupt.

Top module: `nvd_ctrl`

## Requirements
- R1: After reset, every register reads 00h and `irq` is low.
- R2: A write to the control register (index 2) with bit 0 set and bit 7 clear, while no programming cycle runs, loads the byte at the current address into the data register (index 1). The byte reads back on the next cycle, and bit 0 always reads 0.
- R3: The data register changes only on a software write to it or on an accepted fetch. A completing programming cycle leaves it untouched.
- R4: A programming cycle starts only after this sequence: a write of 55h to the key register (index 3), then a write of AAh to it, then, as the next bus write, a control write with bit 1 set. A wrong key byte, a wrong order or any other register write in between cancels the attempt. Idle bus cycles do not cancel it.
- R5: The start control write only takes effect if the write-enable bit (bit 2) was already 1 in the control register before that access.
- R6: Hardware never clears the write-enable bit. Clearing it while a cycle runs does not stop that cycle.
- R7: Control bit 1 (busy) reads 1 for exactly WR_CYCLES cycles. After that, the byte and address that were latched at the start are stored, even if either register was rewritten in the meantime.
- R8: Completion sets control bit 3 (done). The flag stays set until software writes the control register with bit 3 equal to 0. Software cannot set it.
- R9: While bit 7 of the written control value is 1, fetch and start requests are ignored. Bit 7 reads back as written.
- R10: While busy, fetch requests and key-register writes are ignored, so an unlock sent during a cycle does not arm a later start.
- R11: `irq` is high exactly when done and the interrupt-enable bit (bit 4) are both 1.
- R12: The address register keeps all 8 bits, and the store is indexed by the address modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_reg | input | 2 | Register index: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the indexed register (key reads 00h) |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situations to reach are those where the unlock sequence is almost right. Examples are a correct key pair broken by one register write, a repeated 55h, a missing stored enable, and an unlock sent while a cycle is still running. Each of these leaves no visible state in the registers.

The bench drives each near-miss and then tries the start write anyway. It confirms that busy stays low and that the target byte keeps its old value when fetched back. A behavioural model tracks the unlock step, the remaining cycle count and the memory contents, and it is compared with the register read and `irq` on every cycle.

// File: rtl/nvd_pkg.sv
`timescale 1ns/1ps
// Shared register indices, control bit positions, key bytes and the
// unlock state type for the guarded byte store controller.
package nvd_pkg;
    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_KEY  = 2'd3;

    localparam int B_FETCH = 0;
    localparam int B_PROG  = 1;
    localparam int B_ALLOW = 2;
    localparam int B_DONE  = 3;
    localparam int B_IE    = 4;
    localparam int B_SPACE = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_t;
endpackage

// File: rtl/nvd_unlock.sv
`timescale 1ns/1ps
// Unlock sequencer. It tracks the two-byte key pattern on the key register.
// Assumes: each bus write lasts one cycle. Any non-matching write, including
// one to another register, returns it to idle. While busy it stays idle.
module nvd_unlock
    import nvd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_reg,
    input  logic [7:0] bus_wdata,
    input  logic       busy,
    output logic       armed,
    output key_state_t state
);
    key_state_t nxt;

    // Next-state choice from the current bus write.
    always_comb begin
        nxt = state;
        if (bus_we) begin
            if (busy) begin
                nxt = KEY_IDLE;
            end else if (bus_reg == REG_KEY) begin
                case (state)
                    KEY_IDLE: nxt = (bus_wdata == KEY_FIRST)  ? KEY_HALF  : KEY_IDLE;
                    KEY_HALF: nxt = (bus_wdata == KEY_SECOND) ? KEY_ARMED : KEY_IDLE;
                    default:  nxt = KEY_IDLE;
                endcase
            end else begin
                nxt = KEY_IDLE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= nxt;
    end

    assign armed = (state == KEY_ARMED);
endmodule

// File: rtl/nvd_wtimer.sv
`timescale 1ns/1ps
// Programming-cycle timer. It latches the target index and byte at start,
// holds busy for WR_CYCLES clocks, then pulses commit for one cycle.
// Assumes: start is only raised while busy is low.
module nvd_wtimer #(
    parameter int WR_CYCLES = 20,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [7:0]       start_data,
    output logic             busy,
    output logic             commit,
    output logic [IDX_W-1:0] commit_idx,
    output logic [7:0]       commit_data
);
    localparam int CNT_W = $clog2(WR_CYCLES > 1 ? WR_CYCLES : 2);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    assign commit = busy && (remain == '0);

    // Busy flag and down-counter for the cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= LOAD;
        end else if (commit) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end

    // Capture of target index and byte at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_idx  <= '0;
            commit_data <= '0;
        end else if (start) begin
            commit_idx  <= start_idx;
            commit_data <= start_data;
        end
    end
endmodule

// File: rtl/nvd_array.sv
`timescale 1ns/1ps
// Byte storage array with one combinational read port and one write port.
// Assumes: rd_idx and wr_idx are always below DEPTH. Reset clears every cell.
module nvd_array #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data
);
    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // One storage byte, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 cells[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))    cells[g] <= wr_data;
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/nvd_ctrl.sv
`timescale 1ns/1ps
// Guarded byte store controller (top). It holds the address, data and
// control registers, decodes fetch and start requests, and connects the
// unlock sequencer, the cycle timer and the storage array.
// Assumes: 1 <= DEPTH <= 256 and WR_CYCLES >= 1.
module nvd_ctrl
    import nvd_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WR_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_reg,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       addr_q;
    logic [7:0]       data_q;
    logic             allow_q;
    logic             done_q;
    logic             ie_q;
    logic             space_q;
    logic             busy;
    logic             armed;
    key_state_t       key_state;
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    logic [7:0]       commit_data;
    logic [IDX_W-1:0] cur_idx;
    logic [7:0]       cell_rd;
    logic             ctrl_wr;
    logic             fetch_req;
    logic             start_req;

    assign cur_idx   = IDX_W'(32'(addr_q) % 32'(DEPTH));
    assign ctrl_wr   = bus_we && (bus_reg == REG_CTRL);
    assign fetch_req = ctrl_wr && bus_wdata[B_FETCH] && !bus_wdata[B_SPACE] && !busy;
    assign start_req = ctrl_wr && bus_wdata[B_PROG] && !bus_wdata[B_SPACE]
                       && allow_q && armed && !busy;

    nvd_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .armed     (armed),
        .state     (key_state)
    );

    nvd_wtimer #(.WR_CYCLES(WR_CYCLES), .IDX_W(IDX_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_req),
        .start_idx   (cur_idx),
        .start_data  (data_q),
        .busy        (busy),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    nvd_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cur_idx),
        .rd_data (cell_rd),
        .wr_en   (commit),
        .wr_idx  (commit_idx),
        .wr_data (commit_data)
    );

    // Address register, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                addr_q <= '0;
        else if (bus_we && bus_reg == REG_ADDR)    addr_q <= bus_wdata;
    end

    // Data register: a software write or an accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                                data_q <= '0;
        else if (bus_we && bus_reg == REG_DATA)    data_q <= bus_wdata;
        else if (fetch_req)                        data_q <= cell_rd;
    end

    // Software-owned control bits: write enable, interrupt enable, space select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow_q <= 1'b0;
            ie_q    <= 1'b0;
            space_q <= 1'b0;
        end else if (ctrl_wr) begin
            allow_q <= bus_wdata[B_ALLOW];
            ie_q    <= bus_wdata[B_IE];
            space_q <= bus_wdata[B_SPACE];
        end
    end

    // Sticky completion flag: hardware sets it, software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              done_q <= 1'b0;
        else if (commit)                         done_q <= 1'b1;
        else if (ctrl_wr && !bus_wdata[B_DONE])  done_q <= 1'b0;
    end

    // Read multiplexer for the indexed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_reg)
            REG_ADDR: bus_rdata = addr_q;
            REG_DATA: bus_rdata = data_q;
            REG_CTRL: begin
                bus_rdata[B_PROG]  = busy;
                bus_rdata[B_ALLOW] = allow_q;
                bus_rdata[B_DONE]  = done_q;
                bus_rdata[B_IE]    = ie_q;
                bus_rdata[B_SPACE] = space_q;
            end
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = done_q & ie_q;
endmodule

// File: rtl/nvd_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for nvd_ctrl, attached by bind. It watches the bus,
// the busy and flag state, and the unlock sequencer.
module nvd_ctrl_chk
    import nvd_pkg::*;
#(
    parameter int WR_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [1:0] bus_reg,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic       allow,
    input logic       done,
    input logic       irq,
    input key_state_t key_state
);
    int busy_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R4
    start_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we && bus_reg == REG_CTRL && bus_wdata[B_PROG]));
    // R5
    start_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(allow));
    // R6
    allow_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(allow) |-> $past(bus_we && bus_reg == REG_CTRL));
    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_len < WR_CYCLES);
    // R7
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_len) == WR_CYCLES - 1);
    // R8
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(bus_we && bus_reg == REG_CTRL && !bus_wdata[B_DONE]) |=> done);
    // R9
    space_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(bus_wdata[B_SPACE]));
    // R10
    key_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_we && bus_reg == REG_KEY |=> key_state == KEY_IDLE);
    // R11
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind nvd_ctrl nvd_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_reg   (bus_reg),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .allow     (allow_q),
    .done      (done_q),
    .irq       (irq),
    .key_state (key_state)
);

// File: tb/nvd_ctrl_bench.sv
`timescale 1ns/1ps
module nvd_ctrl_bench;
    localparam int DEPTH = 64;
    localparam int WR    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_reg = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done_run = 0;

    always #2 clk = ~clk;

    nvd_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WR)) u_nvd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference model
    int m_mem [DEPTH];
    int m_addr, m_data, m_allow, m_done, m_ie, m_sp, m_step, m_left, m_laddr, m_ldata;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_addr = 0; m_data = 0; m_allow = 0; m_done = 0; m_ie = 0;
            m_sp = 0; m_step = 0; m_left = 0; m_laddr = 0; m_ldata = 0;
        end else begin
            bit busy_now;
            bit fin;
            int w;
            int old_data;
            busy_now = (m_left > 0);
            fin = 0;
            w = int'(bus_wdata);
            if (busy_now) begin
                m_left--;
                if (m_left == 0) begin
                    m_mem[m_laddr] = m_ldata;
                    fin = 1;
                end
            end
            if (bus_we) begin
                case (bus_reg)
                    2'd0: begin m_addr = w; m_step = 0; end
                    2'd1: begin m_data = w; m_step = 0; end
                    2'd2: begin
                        old_data = m_data;
                        if (w[0] && !w[7] && !busy_now) m_data = m_mem[m_addr % DEPTH];
                        if (m_step == 2 && w[1] && m_allow == 1 && !w[7] && !busy_now) begin
                            m_left  = WR;
                            m_laddr = m_addr % DEPTH;
                            m_ldata = old_data;
                        end
                        m_allow = w[2];
                        m_ie    = w[4];
                        m_sp    = w[7];
                        if (!w[3]) m_done = 0;
                        m_step = 0;
                    end
                    default: begin
                        if (busy_now)                      m_step = 0;
                        else if (m_step == 0 && w == 'h55) m_step = 1;
                        else if (m_step == 1 && w == 'hAA) m_step = 2;
                        else                               m_step = 0;
                    end
                endcase
            end
            if (fin) m_done = 1;
        end
    end

    function automatic int model_rdata(input logic [1:0] r);
        case (r)
            2'd0:    return m_addr;
            2'd1:    return m_data;
            2'd2:    return (m_sp << 7) | (m_ie << 4) | (m_done << 3) | (m_allow << 2)
                            | ((m_left > 0 ? 1 : 0) << 1);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            chk({cur_req, " stream rdata"}, int'(bus_rdata), model_rdata(bus_reg));
            chk({cur_req, " stream irq"}, int'(irq), (m_done & m_ie));
        end
    end

    task automatic wr(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_reg = r; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] r, input int exp, input string tag);
        @(negedge clk); #1;
        bus_we = 1'b0; bus_reg = r;
        @(negedge clk);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_cycle();
        repeat (WR + 2) @(negedge clk);
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d);
        wr(2'd0, a); wr(2'd1, d); wr(2'd2, 8'h04);
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    endtask

    task automatic fetch(input logic [7:0] a, input int exp, input string tag);
        wr(2'd0, a); wr(2'd2, 8'h05);
        expect_reg(2'd1, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";
        expect_reg(2'd0, 0, "R1 addr reset");
        expect_reg(2'd1, 0, "R1 data reset");
        expect_reg(2'd2, 0, "R1 ctrl reset");
        expect_reg(2'd3, 0, "R1 key reads zero");
        chk("R1 irq reset", int'(irq), 0);

        cur_req = "R7";
        prog(8'd5, 8'hA5);
        expect_reg(2'd2, 'h06, "R7 busy during cycle");
        wait_cycle();
        expect_reg(2'd2, 'h0C, "R7 done and enable kept (R6)");

        cur_req = "R2";
        fetch(8'd5, 'hA5, "R2 fetch after program");
        expect_reg(2'd2, 'h04, "R2 fetch bit reads zero");

        cur_req = "R12";
        wr(2'd0, 8'd69); wr(2'd2, 8'h01);
        expect_reg(2'd1, 'hA5, "R12 address 69 wraps to 5");
        prog(8'd200, 8'h3C);
        wait_cycle();
        fetch(8'd8, 'h3C, "R12 address 200 stored at 8");
        expect_reg(2'd0, 8, "R12 address keeps 8 bits");

        cur_req = "R3";
        repeat (5) @(negedge clk);
        wr(2'd0, 8'd5);
        expect_reg(2'd1, 'h3C, "R3 data held without fetch");

        cur_req = "R7";
        prog(8'd10, 8'h11);
        wr(2'd0, 8'd11); wr(2'd1, 8'h99);
        wait_cycle();
        expect_reg(2'd1, 'h99, "R3 completion leaves data register");
        fetch(8'd10, 'h11, "R7 latched byte stored at latched address");
        fetch(8'd11, 'h00, "R7 rewritten address not programmed");

        cur_req = "R4";
        wr(2'd0, 8'd20); wr(2'd1, 8'h77); wr(2'd2, 8'h04);
        wr(2'd3, 8'h55); wr(2'd3, 8'h56); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R4 wrong key byte");
        wr(2'd3, 8'h55); wr(2'd0, 8'd20); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R4 register write between keys");
        wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R4 keys in reverse order");
        wr(2'd3, 8'h55); wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R4 repeated first key");
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd1, 8'h77); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R4 data write before start");
        wait_cycle();
        fetch(8'd20, 'h00, "R4 aborted attempts store nothing");

        cur_req = "R5";
        wr(2'd0, 8'd30); wr(2'd1, 8'h5A); wr(2'd2, 8'h00);
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R5 enable set in same access does not start");
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h06, "R5 stored enable allows start");

        cur_req = "R6";
        wr(2'd2, 8'h02);
        expect_reg(2'd2, 'h02, "R6 cycle survives enable clear");
        wait_cycle();
        expect_reg(2'd2, 'h08, "R6 cycle completed");
        fetch(8'd30, 'h5A, "R6 byte stored");

        cur_req = "R8";
        wr(2'd2, 8'h00);
        prog(8'd31, 8'h6B);
        wait_cycle();
        repeat (10) @(negedge clk);
        expect_reg(2'd2, 'h0C, "R8 done sticky over idle");
        wr(2'd2, 8'h0C);
        expect_reg(2'd2, 'h0C, "R8 writing one keeps done");
        wr(2'd2, 8'h00);
        expect_reg(2'd2, 'h00, "R8 writing zero clears done");
        wr(2'd2, 8'h08);
        expect_reg(2'd2, 'h00, "R8 software cannot set done");

        cur_req = "R11";
        wr(2'd2, 8'h10);
        chk("R11 enable alone no irq", int'(irq), 0);
        wr(2'd0, 8'd40); wr(2'd1, 8'hE1); wr(2'd2, 8'h14);
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h16);
        wait_cycle();
        @(negedge clk);
        chk("R11 irq on done with enable", int'(irq), 1);
        wr(2'd2, 8'h0C);
        @(negedge clk);
        chk("R11 irq low with enable off", int'(irq), 0);
        wr(2'd2, 8'h00);

        cur_req = "R9";
        wr(2'd2, 8'h84); wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h86);
        expect_reg(2'd2, 'h84, "R9 start ignored with select set");
        wr(2'd0, 8'd5); wr(2'd2, 8'h81);
        expect_reg(2'd1, 'hE1, "R9 fetch ignored with select set");
        wr(2'd2, 8'h04);
        wait_cycle();
        fetch(8'd40, 'hE1, "R9 location 40 unchanged");

        cur_req = "R10";
        wr(2'd0, 8'd50); wr(2'd1, 8'h42); wr(2'd2, 8'h04);
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
        wr(2'd0, 8'd5); wr(2'd2, 8'h05);
        expect_reg(2'd1, 'h42, "R10 fetch ignored while busy");
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
        wait_cycle();
        wr(2'd2, 8'h06);
        expect_reg(2'd2, 'h04, "R10 unlock during cycle not kept");
        fetch(8'd50, 'h42, "R10 first cycle stored");

        done_run = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done_run) begin
            done_run = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule